// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast master clock into a slower reference tick whose average rate can fall between two integer divide ratios. Each divided period lasts either `base + 2` or `base + 3` master-clock cycles. Periods are grouped into frames of 4096. A programmable number of periods at the start of each frame use the shorter length, and the rest of the frame uses the longer one. The average period is therefore the frame length in cycles divided by 4096.

Software programs two fields through a small register port: a 14-bit base value and a 12-bit short-period count. The divider copies both fields into its working settings only when a frame ends. A frame therefore never mixes old and new settings, even when software updates the two fields many cycles apart. The outputs are a one-cycle tick on the last master-clock cycle of each divided period, and a one-cycle frame marker that coincides with the tick ending the 4096th period.

Top module: `frac_clk_divider`

## Requirements
- R1: While `rst` is high, `tick` and `frame_mark` stay low. The register fields hold their parameter reset values, which default to base 0x2000 and short count 0x0FFF.
- R2: The base register sits at address 0 and holds bits 13:0. The short-count register sits at address 1 and holds bits 11:0. The higher bits of either register read back as zero. Addresses 2 and 3 read zero, and writes to them change nothing.
- R3: The first divided period begins on the first cycle after `rst` falls. The first `tick` therefore comes in cycle `base+2` counted from that cycle.
- R4: Within a frame, the first `s` periods last `base+2` cycles and the remaining `4096-s` periods last `base+3` cycles, where `s` is the short count.
- R5: A short count of 0 behaves exactly like a short count of 1.
- R6: One frame lasts `(base+2)*s + (base+3)*(4096-s)` master-clock cycles.
- R7: `frame_mark` pulses for one cycle, together with `tick`, on the last cycle of period 4096 of each frame, and at no other time.
- R8: Register writes take effect only at the start of the frame that follows them. The working settings stay unchanged between frame ends.
- R9: `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| tick | output | 1 | One-cycle pulse ending each divided period |
| frame_mark | output | 1 | One-cycle pulse ending each 4096-period frame |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any check counts. They also assume that the register port changes only away from the active edge, so that a write lands cleanly in one cycle. The stimulus drives every input shortly after the rising edge. It releases reset only after several cycles. Some writes fall in the middle of a frame, and one pair of writes is split across a long gap, so that the frame-boundary capture is exercised. Base values stay small, so that five whole frames fit in the run, and the short counts cover 0, 1, 2048 and 4095.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_BASE  = 2'd0,
    SEL_SHORT = 2'd1
  } reg_sel_e;

  // A short count of zero is treated as one.
  function automatic int unsigned eff_short_of(int unsigned s);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int unsigned period_ratio(int unsigned base, logic is_short);
    return base + (is_short ? 2 : 3);
  endfunction

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter int BASE_W    = 14,
  parameter int SHORT_W   = 12,
  parameter int DATA_W    = 16,
  parameter int RST_BASE  = 32'h2000,
  parameter int RST_SHORT = 32'h0FFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [BASE_W-1:0]  base_q,
  output logic [SHORT_W-1:0] short_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= BASE_W'(RST_BASE);
      short_q <= SHORT_W'(RST_SHORT);
    end else if (wr_en) begin
      case (addr)
        SEL_BASE:  base_q  <= wdata[BASE_W-1:0];
        SEL_SHORT: short_q <= wdata[SHORT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      SEL_BASE:  rdata = DATA_W'(base_q);
      SEL_SHORT: rdata = DATA_W'(short_q);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/fdiv_sequencer.sv
module fdiv_sequencer
  import fdiv_pkg::*;
#(
  parameter int BASE_W    = 14,
  parameter int SHORT_W   = 12,
  parameter int RST_BASE  = 32'h2000,
  parameter int RST_SHORT = 32'h0FFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [BASE_W-1:0]  base_q,
  input  logic [SHORT_W-1:0] short_q,
  output logic [BASE_W-1:0]  act_base,
  output logic [SHORT_W-1:0] act_short,
  output logic [SHORT_W-1:0] period_idx,
  output logic               in_short,
  output logic               last_period
);

  assign last_period = &period_idx;
  assign in_short    = 32'(period_idx) < eff_short_of(32'(act_short));

  always_ff @(posedge clk) begin
    if (rst) begin
      period_idx <= '0;
      act_base   <= BASE_W'(RST_BASE);
      act_short  <= SHORT_W'(RST_SHORT);
    end else if (tick) begin
      period_idx <= period_idx + 1'b1;
      if (last_period) begin
        act_base  <= base_q;
        act_short <= short_q;
      end
    end
  end

endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);

  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = ratio - CNT_W'(1);
  assign tick     = (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
  import fdiv_pkg::*;
#(
  parameter int BASE_W    = 14,
  parameter int SHORT_W   = 12,
  parameter int DATA_W    = 16,
  parameter int RST_BASE  = 32'h2000,
  parameter int RST_SHORT = 32'h0FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick,
  output logic              frame_mark
);

  localparam int CNT_W = BASE_W + 1;

  logic [BASE_W-1:0]  base_q;
  logic [SHORT_W-1:0] short_q;
  logic [BASE_W-1:0]  act_base;
  logic [SHORT_W-1:0] act_short;
  logic [SHORT_W-1:0] period_idx;
  logic               in_short;
  logic               last_period;
  logic [CNT_W-1:0]   cur_ratio;
  logic [CNT_W-1:0]   cnt;

  fdiv_regs #(
    .BASE_W(BASE_W), .SHORT_W(SHORT_W), .DATA_W(DATA_W),
    .RST_BASE(RST_BASE), .RST_SHORT(RST_SHORT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .base_q(base_q), .short_q(short_q)
  );

  fdiv_sequencer #(
    .BASE_W(BASE_W), .SHORT_W(SHORT_W),
    .RST_BASE(RST_BASE), .RST_SHORT(RST_SHORT)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .base_q(base_q), .short_q(short_q),
    .act_base(act_base), .act_short(act_short), .period_idx(period_idx),
    .in_short(in_short), .last_period(last_period)
  );

  assign cur_ratio = CNT_W'(period_ratio(32'(act_base), in_short));

  fdiv_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .ratio(cur_ratio), .cnt(cnt), .tick(tick)
  );

  assign frame_mark = tick & last_period;

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int BASE_W  = 14,
  parameter int SHORT_W = 12,
  parameter int CNT_W   = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               frame_mark,
  input logic               last_period,
  input logic               in_short,
  input logic [BASE_W-1:0]  act_base,
  input logic [SHORT_W-1:0] act_short,
  input logic [CNT_W-1:0]   cur_ratio
);

  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)       len_q <= '0;
    else if (tick) len_q <= '0;
    else           len_q <= len_q + 1'b1;
  end

  AST_MARK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> (tick && last_period)); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R9

  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_mark |=> ($stable(act_base) && $stable(act_short))); // R8

  AST_SHORT_THEN_LONG: assert property (@(posedge clk) disable iff (rst)
    (tick && !in_short && !last_period) |=> !in_short); // R4

  AST_FRAME_OPENS_SHORT: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> in_short); // R5

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
    tick |-> (CNT_W'(len_q + 1'b1) == cur_ratio)); // R6

endmodule

bind frac_clk_divider fdiv_checker #(
  .BASE_W(BASE_W), .SHORT_W(SHORT_W), .CNT_W(BASE_W + 1)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .frame_mark(frame_mark),
  .last_period(last_period), .in_short(in_short),
  .act_base(act_base), .act_short(act_short), .cur_ratio(cur_ratio)
);

// File: tb/frac_clk_divider_test.sv
module frac_clk_divider_test;

  localparam int RB = 1;
  localparam int RS = 4095;
  localparam int FRAME = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tick;
  logic        frame_mark;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  frac_clk_divider #(.RST_BASE(RB), .RST_SHORT(RS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .frame_mark(frame_mark)
  );

  always #2 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int effs(int s);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int frame_len(int b, int s);
    return (b + 2) * effs(s) + (b + 3) * (FRAME - effs(s));
  endfunction

  // Behavioural reference, evaluated mid-cycle
  int m_cyc, m_idx, m_base, m_short, sh_base, sh_short;
  int rel_cyc, dut_fc, ratio_now;
  bit first_seen, prev_tick, exp_tick, exp_mark;

  always @(negedge clk) begin
    if (rst) begin
      m_cyc = 0; m_idx = 0; m_base = RB; m_short = RS;
      sh_base = RB; sh_short = RS;
      rel_cyc = 0; dut_fc = 0; first_seen = 0; prev_tick = 0;
    end else if (!done) begin
      ratio_now = m_base + ((m_idx < effs(m_short)) ? 2 : 3);
      exp_tick  = (m_cyc == ratio_now - 1);
      exp_mark  = exp_tick && (m_idx == FRAME - 1);
      check(tick === exp_tick, "R4", int'(tick), int'(exp_tick));
      check(frame_mark === exp_mark, "R7", int'(frame_mark), int'(exp_mark));
      if (tick) check(!prev_tick, "R9", int'(prev_tick), 0);
      prev_tick = tick;
      rel_cyc++;
      if (tick && !first_seen) begin
        first_seen = 1;
        check(rel_cyc == RB + 2, "R3", rel_cyc, RB + 2);
      end
      dut_fc++;
      if (frame_mark) begin
        check(dut_fc == frame_len(m_base, m_short), (m_short == 0) ? "R5" : "R6",
              dut_fc, frame_len(m_base, m_short));
        dut_fc = 0;
      end
      // advance; settings captured only at a frame end (R8)
      if (exp_tick) begin
        m_cyc = 0;
        if (exp_mark) begin
          m_idx = 0; m_base = sh_base; m_short = sh_short;
        end else m_idx++;
      end else m_cyc++;
      if (wr_en) begin
        if (addr == 2'd0) sh_base  = int'(wdata & 16'h3FFF);
        if (addr == 2'd1) sh_short = int'(wdata & 16'h0FFF);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(logic [1:0] a, int exp, string req);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(int'(rdata) == exp, req, int'(rdata), exp);
  endtask

  task automatic wait_mark();
    @(negedge clk);
    while (frame_mark !== 1'b1) @(negedge clk);
  endtask

  initial begin
    // R1: quiet outputs and reset register values
    repeat (3) begin
      @(negedge clk);
      check(tick === 1'b0, "R1", int'(tick), 0);
      check(frame_mark === 1'b0, "R1", int'(frame_mark), 0);
    end
    addr = 2'd0; @(negedge clk);
    check(int'(rdata) == RB, "R1", int'(rdata), RB);
    addr = 2'd1; @(negedge clk);
    check(int'(rdata) == RS, "R1", int'(rdata), RS);
    @(posedge clk); #1 rst = 1'b0;

    // Frame 0 (base 1, short 4095): register port checks, R2
    wr(2'd0, 16'hFFFF);
    rd_check(2'd0, 16'h3FFF, "R2");
    wr(2'd2, 16'h1234);
    rd_check(2'd2, 0, "R2");
    rd_check(2'd3, 0, "R2");
    rd_check(2'd0, 16'h3FFF, "R2");
    wr(2'd1, 16'hFFFF);
    rd_check(2'd1, 16'h0FFF, "R2");
    // restore within the same frame; next frame: base 0, short 0 (R5)
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    rd_check(2'd1, 0, "R2");
    wait_mark();
    // Frame 1: split update across a long gap (R8); next base 2, short 1
    wr(2'd0, 16'd2);
    repeat (500) @(posedge clk);
    wr(2'd1, 16'd1);
    wait_mark();
    // Frame 2: next base 3, short 2048
    wr(2'd1, 16'd2048);
    wr(2'd0, 16'd3);
    wait_mark();
    // Frame 3: next base 0, short 4095
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd4095);
    wait_mark();
    // Frame 4 runs with base 0, short 4095
    wait_mark();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule